// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block caches recent virtual-to-physical page translations for 4 KB pages. A requester presents a 32-bit virtual address, the access kind (read or write) and the privilege mode (kernel or user). In the same cycle, the block reports one of three outcomes:

- a hit, together with the physical address;
- a miss, when no valid entry holds the page;
- a protection fault, when the entry exists but the mode does not allow that access.

The upper 20 bits of the address, the page number, are compared against all 40 entries at once. On a hit, the stored frame number is joined to the 12-bit offset, which passes through unchanged.

After a miss, an external page-table walker writes the missing translation through the refill port. The block itself chooses the slot for the new entry, in this order:

1. an empty (invalid) slot;
2. otherwise, a slot that has not been used since the last reference sweep;
3. otherwise, slot 0.

The chosen slot is shown on `victim`. Each successful hit marks its entry as used. A periodic sweep pulse clears all use marks. A flush pulse empties the whole buffer, for example on a context switch.

Top module: `xlat_buffer`

## Requirements
- R1: The buffer has 40 entries, and any page may occupy any entry. A lookup hits when some valid entry holds the requested page number, which is address bits 31:12.
- R2: Lookup results are combinational, in the same cycle as the request. When `lk_valid` is low, `lk_hit`, `lk_miss` and `lk_fault` are all low. When `lk_valid` is high, exactly one of them is high.
- R3: After reset, every entry is invalid. An invalid entry never produces a hit or a fault, whatever page number it last held.
- R4: On a hit, `lk_paddr` equals the stored 20-bit frame number in bits 31:12 and the unchanged address bits 11:0. When there is no hit, `lk_paddr` is zero.
- R5: `rf_perm` holds four permission bits, indexed by {`lk_kernel`,`lk_write`}:
  - bit 0: user read;
  - bit 1: user write;
  - bit 2: kernel read;
  - bit 3: kernel write.

  A matching access whose bit is clear raises `lk_fault` instead of `lk_hit`, and `lk_paddr` stays zero.
- R6: A refill takes effect at the next rising clock edge. If a valid entry already holds `rf_vpn`, that entry is overwritten in place and no duplicate is created.
- R7: A hit sets the entry's reference bit. A `ref_clear` pulse clears all reference bits, and takes priority over a hit in the same cycle. Refilling an entry clears its reference bit.
- R8: `victim` gives the slot a new refill would use:
  - the lowest-indexed invalid entry;
  - otherwise, the lowest-indexed entry whose reference bit is clear;
  - otherwise, entry 0.
- R9: A `flush` pulse invalidates all entries at the next edge. It takes priority over a refill in the same cycle, and the refill is then discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| lk_kernel | input | 1 | 1 = kernel mode, 0 = user mode |
| lk_hit | output | 1 | Translation found and permitted |
| lk_miss | output | 1 | No valid entry for the page |
| lk_fault | output | 1 | Entry found but access not permitted |
| lk_paddr | output | 32 | Physical address on hit, else zero |
| flush | input | 1 | Invalidate all entries |
| ref_clear | input | 1 | Clear all reference bits |
| rf_valid | input | 1 | Write a new translation |
| rf_vpn | input | 20 | Page number of the new translation |
| rf_pfn | input | 20 | Frame number of the new translation |
| rf_perm | input | 4 | Permission bits, encoded as in R5 |
| victim | output | 6 | Slot the next refill of a new page would use |

## Verification
The hardest state to reach is the second and third steps of replacement. Slots are only judged by their reference bits once all 40 are valid, so the bench first fills every slot while watching `victim` step upward. It then uses hits on chosen pages to set chosen reference bits, and watches `victim` move to the first unreferenced slot. Refilling a page that is already present shows that slot as the victim again, because the refill clears its reference bit. Finally, hits on every page make `victim` fall back to slot 0, and a new refill there removes the old page.

// File: rtl/xlat_buffer.sv
module xlat_buffer #(
  parameter int ENTRIES = 40,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFS_W   = 12,
  localparam int VPN_W  = VA_W - OFS_W,
  localparam int PFN_W  = PA_W - OFS_W,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic             lk_write,
  input  logic             lk_kernel,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic             lk_fault,
  output logic [PA_W-1:0]  lk_paddr,
  input  logic             flush,
  input  logic             ref_clear,
  input  logic             rf_valid,
  input  logic [VPN_W-1:0] rf_vpn,
  input  logic [PFN_W-1:0] rf_pfn,
  input  logic [3:0]       rf_perm,
  output logic [IW-1:0]    victim
);

  logic [ENTRIES-1:0] vld_q, ref_q, ref_n;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  logic [3:0]         perm_q [ENTRIES];

  logic [ENTRIES-1:0] lk_match, rf_match;
  logic [VPN_W-1:0]   lk_vpn;
  assign lk_vpn = lk_vaddr[VA_W-1:OFS_W];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_match[g] = vld_q[g] && (vpn_q[g] == lk_vpn);
    assign rf_match[g] = vld_q[g] && (vpn_q[g] == rf_vpn);
  end

  logic [IW-1:0] hit_idx, rf_hit_idx, free_idx, cold_idx;
  logic          any_free, any_cold;

  always_comb begin
    hit_idx    = '0;
    rf_hit_idx = '0;
    free_idx   = '0;
    cold_idx   = '0;
    any_free   = 1'b0;
    any_cold   = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lk_match[i]) hit_idx = IW'(i);
      if (rf_match[i]) rf_hit_idx = IW'(i);
      if (!vld_q[i]) begin
        free_idx = IW'(i);
        any_free = 1'b1;
      end
      if (vld_q[i] && !ref_q[i]) begin
        cold_idx = IW'(i);
        any_cold = 1'b1;
      end
    end
  end

  assign victim = any_free ? free_idx : (any_cold ? cold_idx : '0);

  logic          found, allowed;
  logic [3:0]    hit_perm;
  logic [IW-1:0] rf_idx;

  assign found    = lk_valid && (lk_match != '0);
  assign hit_perm = perm_q[hit_idx];
  assign allowed  = hit_perm[{lk_kernel, lk_write}];
  assign lk_hit   = found && allowed;
  assign lk_fault = found && !allowed;
  assign lk_miss  = lk_valid && (lk_match == '0);
  assign lk_paddr = lk_hit ? {pfn_q[hit_idx], lk_vaddr[OFS_W-1:0]} : '0;
  assign rf_idx   = (rf_match != '0) ? rf_hit_idx : victim;

  always_comb begin
    ref_n = ref_q;
    if (lk_hit) ref_n[hit_idx] = 1'b1;
    if (ref_clear) ref_n = '0;
    if (rf_valid) ref_n[rf_idx] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      vld_q <= '0;
      ref_q <= '0;
    end else begin
      ref_q <= ref_n;
      if (rf_valid) vld_q[rf_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !flush && rf_valid) begin
      vpn_q[rf_idx]  <= rf_vpn;
      pfn_q[rf_idx]  <= rf_pfn;
      perm_q[rf_idx] <= rf_perm;
    end
  end

  a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> ($countones({lk_hit, lk_miss, lk_fault}) == 1));
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !(lk_hit || lk_miss || lk_fault));
  a_r4_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_paddr[OFS_W-1:0] == lk_vaddr[OFS_W-1:0]));
  a_r6_no_duplicate: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lk_match) <= 1);
  a_r7_sweep_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ref_clear |=> (ref_q == '0));
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld_q == '0));
  a_r3_reset_empty: assert property (@(posedge clk)
    !rst_n |=> (vld_q == '0));

endmodule

// File: tb/xlat_buffer_test.sv
module xlat_buffer_test;
  logic        clk = 0, rst_n = 0;
  logic        lk_valid = 0, lk_write = 0, lk_kernel = 0;
  logic [31:0] lk_vaddr = 0;
  logic        lk_hit, lk_miss, lk_fault;
  logic [31:0] lk_paddr;
  logic        flush = 0, ref_clear = 0, rf_valid = 0;
  logic [19:0] rf_vpn = 0, rf_pfn = 0;
  logic [3:0]  rf_perm = 0;
  logic [5:0]  victim;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  xlat_buffer uut (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic look(input string tag, input logic [31:0] va, input logic wr, input logic kern,
                      input logic [2:0] exp_hmf, input logic [31:0] exp_pa);
    @(negedge clk);
    lk_valid = 1; lk_vaddr = va; lk_write = wr; lk_kernel = kern;
    #1;
    check(tag, {lk_hit, lk_miss, lk_fault}, exp_hmf);
    check(tag, lk_paddr, exp_pa);
    @(posedge clk); #1;
    lk_valid = 0;
  endtask

  task automatic refill(input logic [19:0] vpn, input logic [19:0] pfn, input logic [3:0] perm);
    @(negedge clk);
    rf_valid = 1; rf_vpn = vpn; rf_pfn = pfn; rf_perm = perm;
    @(posedge clk); #1;
    rf_valid = 0;
  endtask

  task automatic pulse_flush();
    @(negedge clk); flush = 1;
    @(posedge clk); #1; flush = 0;
  endtask

  task automatic pulse_sweep();
    @(negedge clk); ref_clear = 1;
    @(posedge clk); #1; ref_clear = 0;
  endtask

  task automatic chk_victim(input string tag, input int exp);
    @(negedge clk); #1;
    check(tag, victim, exp);
  endtask

  task automatic t_reset();
    chk_victim("R3 reset victim", 0);
    look("R3 reset lookup miss", 32'h1234_5678, 0, 0, 3'b010, 0);
    look("R2 kernel write miss after reset", 32'h0, 1, 1, 3'b010, 0);
    @(negedge clk);
    check("R2 idle outputs low", {lk_hit, lk_miss, lk_fault}, 3'b000);
  endtask

  task automatic t_basic();
    refill(20'h00ABC, 20'h55501, 4'hF);
    chk_victim("R8 next free slot", 1);
    look("R1 R4 basic hit", 32'h00AB_C123, 0, 0, 3'b100, 32'h5550_1123);
    refill(20'hFFFFF, 20'h00002, 4'hF);
    look("R4 top page max offset", 32'hFFFF_FFFF, 1, 1, 3'b100, 32'h0000_2FFF);
    look("R1 unmapped page miss", 32'h00AB_D123, 0, 0, 3'b010, 0);
  endtask

  task automatic t_perm();
    refill(20'h00010, 20'h0AAAA, 4'b0101);
    look("R5 user read allowed", 32'h0001_0004, 0, 0, 3'b100, 32'h0AAA_A004);
    look("R5 user write fault", 32'h0001_0004, 1, 0, 3'b001, 0);
    look("R5 kernel write fault", 32'h0001_0004, 1, 1, 3'b001, 0);
    look("R5 kernel read allowed", 32'h0001_0008, 0, 1, 3'b100, 32'h0AAA_A008);
    refill(20'h00011, 20'h0BBBB, 4'b1100);
    look("R5 user read of kernel page fault", 32'h0001_1000, 0, 0, 3'b001, 0);
    look("R5 kernel write allowed", 32'h0001_1FF0, 1, 1, 3'b100, 32'h0BBB_BFF0);
    refill(20'h00012, 20'h0CCCC, 4'b0010);
    look("R5 user write-only page read fault", 32'h0001_2000, 0, 0, 3'b001, 0);
    look("R5 user write-only page write hit", 32'h0001_2010, 1, 0, 3'b100, 32'h0CCC_C010);
  endtask

  task automatic t_flush();
    pulse_flush();
    look("R9 R3 stale page after flush misses", 32'h00AB_C123, 0, 0, 3'b010, 0);
    chk_victim("R9 victim after flush", 0);
    @(negedge clk);
    flush = 1; rf_valid = 1; rf_vpn = 20'h00ABC; rf_pfn = 20'h11111; rf_perm = 4'hF;
    @(posedge clk); #1;
    flush = 0; rf_valid = 0;
    look("R9 refill dropped under flush", 32'h00AB_C000, 0, 0, 3'b010, 0);
    chk_victim("R9 still empty", 0);
    refill(20'h00ABC, 20'h22222, 4'hF);
    look("R6 refill visible next cycle", 32'h00AB_C010, 0, 0, 3'b100, 32'h2222_2010);
    pulse_flush();
  endtask

  task automatic t_replace();
    for (int i = 0; i < 40; i++) begin
      chk_victim("R8 fill order", i);
      refill(20'h00200 + 20'(i), 20'h00300 + 20'(i), 4'hF);
    end
    chk_victim("R8 full, all cold", 0);
    look("R1 last slot hit", 32'h0022_7ABC, 0, 0, 3'b100, 32'h0032_7ABC);
    pulse_sweep();
    for (int i = 0; i < 10; i++)
      look("R1 hit fill", 32'h0020_0000 + (i << 12), 0, 0, 3'b100, 32'h0030_0000 + (i << 12));
    chk_victim("R7 R8 first cold slot", 10);
    refill(20'h00203, 20'h00AAA, 4'hF);
    chk_victim("R6 R7 overwritten slot cold again", 3);
    look("R6 overwrite in place", 32'h0020_3444, 0, 0, 3'b100, 32'h00AA_A444);
    chk_victim("R7 hit marks slot", 10);
    pulse_sweep();
    chk_victim("R7 sweep clears marks", 0);
    for (int i = 0; i < 40; i++)
      look("R1 hit all", 32'h0020_0000 + (i << 12), 0, 0, 3'b100,
           (i == 3) ? 32'h00AA_A000 : 32'h0030_0000 + (i << 12));
    chk_victim("R8 all referenced fallback", 0);
    refill(20'h00999, 20'h00777, 4'hF);
    look("R8 evicted page misses", 32'h0020_0000, 0, 0, 3'b010, 0);
    look("R8 new page hits", 32'h0099_9001, 0, 0, 3'b100, 32'h0077_7001);
    look("R8 neighbour kept", 32'h0020_1001, 0, 0, 3'b100, 32'h0030_1001);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_basic();
    t_perm();
    t_flush();
    t_replace();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule